// File: doc/BRIEF.md
# ULPI Link-Side Low-Power Controller

This block sits in the link of a ULPI transceiver interface. It puts the PHY into its low-power state, watches the bus while the PHY is asleep, and brings it back. A one-cycle `sleep_req` starts a register write that clears the suspend-control bit of the PHY's function control register. The write uses the normal command byte, data byte and stop sequence. Once the PHY takes the bus, `suspended` rises. From then on, every cycle with DIR high is decoded as the low-power bus map: the two line-state bits come from data bits 1:0, and the latched interrupt flag comes from data bit 3. All other bits are ignored.

A `wake_req` is held pending until `clk_ready` reports that the PHY clock runs again. STP is then raised and kept high until the PHY drops DIR. After one turnaround cycle the block is idle again. In idle, any status byte the PHY sends (DIR high, NXT low) is reported on `status_valid`/`status_byte`. Nothing waits for that byte, so a PHY that sends no status after exit does not stall the block. The PHY may also leave low-power mode on its own by dropping DIR.

Top module: `lpm_link_ctrl`

## Requirements
- R1: After reset, `ulpi_stp`, `ulpi_data_out`, `suspended`, `line_state`, `irq` and `status_valid` are all zero.
- R2: A `sleep_req` in idle with DIR low puts the command byte 0x84 (bits 7:6 = 2'b10, bits 5:0 = register address 0x04) on `ulpi_data_out` from the next cycle. The byte is held until NXT is seen high with DIR low. Then the data byte 0x09 (base value 0x49 with bit 6 cleared) is driven. The next NXT gives exactly one cycle of STP high with data 0x00.
- R3: If DIR is high during the command or data phase, the write restarts from the command byte. It continues only on NXT with DIR low.
- R4: After the write stop cycle, the first cycle with DIR high is a turnaround. `suspended` rises after it, and that byte never reaches `line_state` or `irq`.
- R5: While suspended and not waking, each DIR-high cycle loads data bits 1:0 into `line_state` and data bit 3 into `irq`, visible one cycle later. Data bits 2 and 7:4 have no effect.
- R6: A `wake_req` while suspended is remembered. STP rises in the cycle after `clk_ready` is first sampled high, and never before.
- R7: STP stays high until DIR is sampled low. STP and `suspended` fall in the following cycle. That cycle is a turnaround, and the block is idle after it. `line_state` and `irq` are frozen while STP is held.
- R8: If DIR falls while suspended without a wake request, `suspended` falls in the next cycle, the exit turnaround follows, and STP never goes high.
- R9: In idle, the first DIR-high cycle is a turnaround. Each later cycle with DIR high and NXT low gives a one-cycle `status_valid` pulse one cycle later, with that byte on `status_byte`. `status_byte` holds its value afterwards.
- R10: A `wake_req` outside the suspended state has no effect: STP stays low and the block stays idle.
- R11: After an exit with no status byte, a new `sleep_req` is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ULPI clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Pulse: start entry into low-power mode |
| wake_req | input | 1 | Pulse: request exit from low-power mode |
| clk_ready | input | 1 | PHY clock is running again |
| ulpi_dir | input | 1 | Bus direction from the PHY |
| ulpi_nxt | input | 1 | Throttle signal from the PHY |
| ulpi_data_in | input | 8 | Bus data seen from the PHY |
| ulpi_data_out | output | 8 | Bus data driven by the link |
| ulpi_stp | output | 1 | Stop / wake line to the PHY |
| suspended | output | 1 | PHY is in low-power mode |
| line_state | output | 2 | Line state decoded during suspend |
| irq | output | 1 | Interrupt flag decoded during suspend |
| status_valid | output | 1 | One-cycle pulse: status byte captured |
| status_byte | output | 8 | Last status byte received in idle |

## Verification
The hardest situations to reach are those where the PHY's DIR changes in the middle of a link action: DIR rising during the write phases, and DIR falling while the wake STP is held. A table of per-cycle PHY responses drives DIR, NXT and data by hand, so exact edge placement is possible. The bench places DIR high while the data byte is on the bus, and drops DIR during suspend with no wake request. The table also loads reserved data bits with ones and places a byte in every turnaround cycle, so that a design reading the wrong cycle or bit shows up in `line_state`, `irq` or `status_byte`.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int ULPI_W  = 8;
  localparam int LS_W    = 2;
  localparam int IRQ_POS = 3;
  localparam int ADDR_W  = 6;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_TXCMD,
    ST_TXDATA,
    ST_TXSTP,
    ST_ENTER_WAIT,
    ST_SUSP,
    ST_WAKE,
    ST_EXIT_TA,
    ST_RX
  } lpm_state_e;

  function automatic logic [ULPI_W-1:0] regwr_cmd(input logic [ADDR_W-1:0] addr);
    return {2'b10, addr};
  endfunction
endpackage

// File: rtl/lpm_seq_fsm.sv
module lpm_seq_fsm
  import lpm_pkg::*;
#(
  parameter logic [ADDR_W-1:0] REG_ADDR   = 6'h04,
  parameter logic [ULPI_W-1:0] FCTRL_BASE = 8'h49,
  parameter int                SUSP_BIT   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req,
  input  logic              wake_req,
  input  logic              clk_ready,
  input  logic              dir,
  input  logic              nxt,
  output logic              stp_o,
  output logic [ULPI_W-1:0] data_o,
  output logic              suspended_o,
  output logic              sample_en_o,
  output logic              cap_en_o
);
  localparam logic [ULPI_W-1:0] WR_VAL  = FCTRL_BASE & ~(ULPI_W'(1) << SUSP_BIT);
  localparam logic [ULPI_W-1:0] CMD_VAL = regwr_cmd(REG_ADDR);

  lpm_state_e state_q, state_d;
  logic       wake_pend_q, wake_pend_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:       if (dir) state_d = ST_RX;
                     else if (sleep_req) state_d = ST_TXCMD;
      ST_TXCMD:      if (!dir && nxt) state_d = ST_TXDATA;
      ST_TXDATA:     if (dir) state_d = ST_TXCMD;
                     else if (nxt) state_d = ST_TXSTP;
      ST_TXSTP:      state_d = ST_ENTER_WAIT;
      ST_ENTER_WAIT: if (dir) state_d = ST_SUSP;
      ST_SUSP:       if (!dir) state_d = ST_EXIT_TA;
                     else if ((wake_pend_q || wake_req) && clk_ready) state_d = ST_WAKE;
      ST_WAKE:       if (!dir) state_d = ST_EXIT_TA;
      ST_EXIT_TA:    state_d = ST_IDLE;
      ST_RX:         if (!dir) state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    wake_pend_d = (state_q == ST_SUSP) && (state_d == ST_SUSP) && (wake_pend_q || wake_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      wake_pend_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      wake_pend_q <= wake_pend_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_TXCMD:  data_o = CMD_VAL;
      ST_TXDATA: data_o = WR_VAL;
      default:   data_o = '0;
    endcase
  end

  assign stp_o       = (state_q == ST_TXSTP) || (state_q == ST_WAKE);
  assign suspended_o = (state_q == ST_SUSP) || (state_q == ST_WAKE);
  assign sample_en_o = (state_q == ST_SUSP) && dir;
  assign cap_en_o    = (state_q == ST_RX) && dir && !nxt;

  // R2: command byte stays put until the PHY accepts it
  assert_cmd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TXCMD && !nxt) |=> (data_o == CMD_VAL));

  // R2: the stop of a register write lasts one cycle
  assert_wr_stp_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stp_o && !suspended_o) |=> !stp_o);

  // R6: no wake STP while the PHY clock is not confirmed
  assert_stp_needs_clk_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SUSP && !clk_ready) |=> !stp_o);

  // R7: STP dropped the cycle after DIR is seen low
  assert_stp_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAKE && !dir) |=> !stp_o);

  // R10: wake request in idle leaves STP low
  assert_idle_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !sleep_req) |=> !stp_o);
endmodule

// File: rtl/lpm_susp_decode.sv
module lpm_susp_decode
  import lpm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sample_en,
  input  logic [LS_W-1:0] ls_bits,
  input  logic            irq_bit,
  output logic [LS_W-1:0] line_state,
  output logic            irq
);
  logic [LS_W-1:0] ls_d;
  logic            irq_d;

  always_comb begin
    ls_d  = line_state;
    irq_d = irq;
    if (sample_en) begin
      ls_d  = ls_bits;
      irq_d = irq_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_state <= '0;
      irq        <= 1'b0;
    end else begin
      line_state <= ls_d;
      irq        <= irq_d;
    end
  end

  // R5: interrupt flag follows the sampled bus bit
  assert_irq_track_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |=> (irq == $past(irq_bit)));

  // R7: values frozen when not sampling
  assert_ls_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> $stable(line_state));
endmodule

// File: rtl/lpm_status_capture.sv
module lpm_status_capture
  import lpm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [ULPI_W-1:0] data_in,
  output logic              status_valid,
  output logic [ULPI_W-1:0] status_byte
);
  logic [ULPI_W-1:0] byte_d;

  always_comb begin
    byte_d = status_byte;
    if (cap_en) byte_d = data_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_valid <= 1'b0;
      status_byte  <= '0;
    end else begin
      status_valid <= cap_en;
      status_byte  <= byte_d;
    end
  end

  // R9: a captured byte appears with its pulse
  assert_status_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (status_valid && status_byte == $past(data_in)));
endmodule

// File: rtl/lpm_link_ctrl.sv
module lpm_link_ctrl
  import lpm_pkg::*;
#(
  parameter logic [ADDR_W-1:0] REG_ADDR   = 6'h04,
  parameter logic [ULPI_W-1:0] FCTRL_BASE = 8'h49,
  parameter int                SUSP_BIT   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req,
  input  logic              wake_req,
  input  logic              clk_ready,
  input  logic              ulpi_dir,
  input  logic              ulpi_nxt,
  input  logic [ULPI_W-1:0] ulpi_data_in,
  output logic [ULPI_W-1:0] ulpi_data_out,
  output logic              ulpi_stp,
  output logic              suspended,
  output logic [LS_W-1:0]   line_state,
  output logic              irq,
  output logic              status_valid,
  output logic [ULPI_W-1:0] status_byte
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  logic       sample_en;
  logic       cap_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  lpm_seq_fsm #(
    .REG_ADDR  (REG_ADDR),
    .FCTRL_BASE(FCTRL_BASE),
    .SUSP_BIT  (SUSP_BIT)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .sleep_req  (sleep_req),
    .wake_req   (wake_req),
    .clk_ready  (clk_ready),
    .dir        (ulpi_dir),
    .nxt        (ulpi_nxt),
    .stp_o      (ulpi_stp),
    .data_o     (ulpi_data_out),
    .suspended_o(suspended),
    .sample_en_o(sample_en),
    .cap_en_o   (cap_en)
  );

  lpm_susp_decode u_decode (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sample_en (sample_en),
    .ls_bits   (ulpi_data_in[LS_W-1:0]),
    .irq_bit   (ulpi_data_in[IRQ_POS]),
    .line_state(line_state),
    .irq       (irq)
  );

  lpm_status_capture u_status (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cap_en      (cap_en),
    .data_in     (ulpi_data_in),
    .status_valid(status_valid),
    .status_byte (status_byte)
  );

  // R4: suspend is only declared after the PHY has taken the bus
  assert_enter_dir_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(suspended) |-> $past(ulpi_dir));

  // R8: every exit from suspend follows DIR seen low
  assert_exit_dir_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(suspended) |-> !$past(ulpi_dir));
endmodule

// File: tb/lpm_link_ctrl_bench.sv
module lpm_link_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sleep_req, wake_req, clk_ready, dir, nxt;
  logic [7:0] din;
  logic [7:0] dout;
  logic       stp, susp, irq, sv;
  logic [1:0] ls;
  logic [7:0] st;
  int         n_run  = 0;
  int         n_fail = 0;
  bit         done   = 0;

  always #5 clk = ~clk;

  lpm_link_ctrl u_lpm_link_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
    .clk_ready(clk_ready), .ulpi_dir(dir), .ulpi_nxt(nxt), .ulpi_data_in(din),
    .ulpi_data_out(dout), .ulpi_stp(stp), .suspended(susp), .line_state(ls),
    .irq(irq), .status_valid(sv), .status_byte(st)
  );

  function automatic logic [34:0] vec(
    input logic sl, input logic wk, input logic rdy, input logic dr, input logic nx,
    input logic [7:0] d, input logic e_stp, input logic [7:0] e_do, input logic e_su,
    input logic [1:0] e_ls, input logic e_irq, input logic e_sv, input logic [7:0] e_st);
    return {sl, wk, rdy, dr, nx, d, e_stp, e_do, e_su, e_ls, e_irq, e_sv, e_st};
  endfunction

  localparam int NV = 17;
  localparam logic [34:0] TABLE [NV] = '{
    vec(1,0,0,0,0,8'h00, 0,8'h84,0,2'd0,0,0,8'h00), // R2 command
    vec(0,0,0,0,0,8'h00, 0,8'h84,0,2'd0,0,0,8'h00), // R2 hold
    vec(0,0,0,0,1,8'h00, 0,8'h09,0,2'd0,0,0,8'h00), // R2 data byte
    vec(0,0,0,0,1,8'h00, 1,8'h00,0,2'd0,0,0,8'h00), // R2 stop
    vec(0,0,0,0,0,8'h00, 0,8'h00,0,2'd0,0,0,8'h00), // R4 wait
    vec(0,0,0,1,0,8'hFF, 0,8'h00,1,2'd0,0,0,8'h00), // R4 turnaround ignored
    vec(0,0,0,1,0,8'hF6, 0,8'h00,1,2'd2,0,0,8'h00), // R5 reserved ones
    vec(0,0,0,1,0,8'h09, 0,8'h00,1,2'd1,1,0,8'h00), // R5 irq
    vec(0,1,0,1,0,8'h01, 0,8'h00,1,2'd1,0,0,8'h00), // R6 wake, no clock
    vec(0,0,0,1,0,8'h01, 0,8'h00,1,2'd1,0,0,8'h00), // R6 still waiting
    vec(0,0,1,1,0,8'h02, 1,8'h00,1,2'd2,0,0,8'h00), // R6 clock ready
    vec(0,0,1,1,0,8'h08, 1,8'h00,1,2'd2,0,0,8'h00), // R7 held, frozen
    vec(0,0,0,0,0,8'h00, 0,8'h00,0,2'd2,0,0,8'h00), // R7 release
    vec(0,0,0,0,0,8'h00, 0,8'h00,0,2'd2,0,0,8'h00), // R7 idle
    vec(0,0,0,1,0,8'hAA, 0,8'h00,0,2'd2,0,0,8'h00), // R9 turnaround
    vec(0,0,0,1,0,8'h5C, 0,8'h00,0,2'd2,0,1,8'h5C), // R9 status
    vec(0,0,0,0,0,8'h00, 0,8'h00,0,2'd2,0,0,8'h5C)  // R9 held
  };

  function automatic string tag_of(input int i);
    if (i < 4)  return "R2";
    if (i < 6)  return "R4";
    if (i < 8)  return "R5";
    if (i < 11) return "R6";
    if (i < 14) return "R7";
    return "R9";
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic e_stp, input logic [7:0] e_do,
    input logic e_su, input logic [1:0] e_ls, input logic e_irq, input logic e_sv, input logic [7:0] e_st);
    chk(req, "stp",          {7'd0, stp},  {7'd0, e_stp});
    chk(req, "data_out",     dout,         e_do);
    chk(req, "suspended",    {7'd0, susp}, {7'd0, e_su});
    chk(req, "line_state",   {6'd0, ls},   {6'd0, e_ls});
    chk(req, "irq",          {7'd0, irq},  {7'd0, e_irq});
    chk(req, "status_valid", {7'd0, sv},   {7'd0, e_sv});
    chk(req, "status_byte",  st,           e_st);
  endtask

  task automatic step(input logic sl, input logic wk, input logic rdy, input logic dr,
    input logic nx, input logic [7:0] d);
    sleep_req = sl; wake_req = wk; clk_ready = rdy; dir = dr; nxt = nx; din = d;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    step(0,0,0,0,0,8'h00);
    step(0,0,0,0,0,8'h00);
    rst_n = 1'b1;
    step(0,0,0,0,0,8'h00);
    step(0,0,0,0,0,8'h00);
    step(0,0,0,0,0,8'h00);
    // R1 reset state
    chk_all("R1", 0, 8'h00, 0, 2'd0, 0, 0, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [34:0] v;
      v = TABLE[i];
      step(v[34], v[33], v[32], v[31], v[30], v[29:22]);
      chk_all(tag_of(i), v[21], v[20:13], v[12], v[11:10], v[9], v[8], v[7:0]);
    end

    // R10: wake outside suspend does nothing
    step(0,1,1,0,0,8'h00);
    chk_all("R10", 0, 8'h00, 0, 2'd2, 0, 0, 8'h5C);
    step(0,0,1,0,0,8'h00);
    chk_all("R10", 0, 8'h00, 0, 2'd2, 0, 0, 8'h5C);

    // R3: DIR during the data phase restarts the write
    step(1,0,0,0,0,8'h00); chk_all("R3", 0, 8'h84, 0, 2'd2, 0, 0, 8'h5C);
    step(0,0,0,0,1,8'h00); chk_all("R3", 0, 8'h09, 0, 2'd2, 0, 0, 8'h5C);
    step(0,0,0,1,0,8'h77); chk_all("R3", 0, 8'h84, 0, 2'd2, 0, 0, 8'h5C);
    step(0,0,0,1,1,8'h77); chk_all("R3", 0, 8'h84, 0, 2'd2, 0, 0, 8'h5C);
    step(0,0,0,0,1,8'h00); chk_all("R3", 0, 8'h09, 0, 2'd2, 0, 0, 8'h5C);
    step(0,0,0,0,1,8'h00); chk_all("R3", 1, 8'h00, 0, 2'd2, 0, 0, 8'h5C);
    step(0,0,0,0,0,8'h00); chk_all("R3", 0, 8'h00, 0, 2'd2, 0, 0, 8'h5C);

    // R8: PHY leaves suspend on its own
    step(0,0,0,1,0,8'h00); chk_all("R4", 0, 8'h00, 1, 2'd2, 0, 0, 8'h5C);
    step(0,0,0,1,0,8'h03); chk_all("R5", 0, 8'h00, 1, 2'd3, 0, 0, 8'h5C);
    step(0,0,1,0,0,8'h00); chk_all("R8", 0, 8'h00, 0, 2'd3, 0, 0, 8'h5C);
    step(0,0,0,0,0,8'h00); chk_all("R8", 0, 8'h00, 0, 2'd3, 0, 0, 8'h5C);

    // R11: no status byte came, a new entry starts at once
    step(1,0,0,0,0,8'h00); chk_all("R11", 0, 8'h84, 0, 2'd3, 0, 0, 8'h5C);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule